// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of an emulated byte-wide nonvolatile memory. While the memory's internal programming cycle runs, it replaces the array read data with a status byte. The host can poll this status byte to learn when the write has finished. Two indications are given. The polling bit carries the inverse of the top bit of the last byte written. The toggle bit changes value from one completed read access to the next. The remaining status bits repeat the last written byte. When the busy flag is low, the block passes the array data through unchanged.

The read strobes (active-low chip select, output enable and write enable) are sampled on the block clock. The data bus and its output-enable are registered. A read access is qualified in one cycle and its data appears after the following clock edge. The drive enable stands in for the tristate condition of a real pad. The read bus has no back-pressure: a qualified access is answered in every cycle it is held, and the host simply stops sampling. The polling bit sits at the most significant bit position and the toggle bit one position below it. These positions are parameters with those defaults.

Top module: `wr_status_resp`

## Requirements
- R1: The output-enable `rd_oe` is 1 in the cycle after a clock edge that sampled `sel_n`=0, `oen_n`=0 and `wen_n`=1; after any other sample it is 0 and `rd_data` is all zeros.
- R2: With `prog_busy`=0 at the sampling edge, a qualified read returns `arr_rdata` unchanged on all eight bits.
- R3: With `prog_busy`=1 at the sampling edge, a qualified read returns bit 7 as the inverse of bit 7 of `last_wr`.
- R4: With `prog_busy`=1, bit 6 of a qualified read returns a toggle state. This state inverts at the edge where a read access ends while busy is high, so successive accesses alternate 0, 1, 0, ...
- R5: With `prog_busy`=1, bits 5 to 0 of a qualified read equal bits 5 to 0 of `last_wr`.
- R6: While `prog_busy`=0, ending a read access leaves the toggle state unchanged; the next busy read shows the value held from before.
- R7: An access ends when `sel_n` rises, when `oen_n` rises, or when `wen_n` falls; each of these advances the toggle state while busy.
- R8: A read sampled in the same cycle that `prog_busy` drops returns true array data.
- R9: Reset (`rst_n`=0, asynchronous) forces `rd_oe`=0, `rd_data`=0 and the toggle state to 0.
- R10: Within one uninterrupted busy read access, bit 6 stays constant from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| oen_n | input | 1 | Output enable strobe, active low |
| wen_n | input | 1 | Write enable strobe, active low |
| prog_busy | input | 1 | High while internal programming runs |
| last_wr | input | 8 | Last byte accepted for programming |
| arr_rdata | input | 8 | Array data at the current address |
| rd_data | output | 8 | Returned read data, zero when not driven |
| rd_oe | output | 1 | High when the data bus is driven |

## Verification
Every result on `rd_data` and `rd_oe` is due exactly one clock edge after the strobes, busy flag and data inputs are sampled. The toggle state moves at the edge where the access ends, so its new value first shows up on the data of the next qualified access. The bench therefore changes inputs on the falling clock edge and samples one full cycle later, on the following falling edge. This keeps every expected value in the vector table aligned to a single register stage. The checker states the same one-edge relation with `|=>` properties against the sampled inputs.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  // Source of one returned bit during a qualified read.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } bit_src_e;

  // Picks the source of the returned byte from the sampled read state.
  function automatic bit_src_e pick_src(input logic rd_now, input logic busy);
    if (!rd_now)   return SRC_NONE;
    else if (busy) return SRC_STATUS;
    else           return SRC_ARRAY;
  endfunction

endpackage

// File: rtl/wsr_access_detect.sv
module wsr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic oen_n,
  input  logic wen_n,
  output logic rd_now,
  output logic rd_end
);

  logic rd_prev_q;

  // An access is qualified only when both selects are low and no write strobe is active.
  assign rd_now = ~sel_n & ~oen_n & wen_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rd_rst_active(rst_n)) rd_prev_q <= 1'b0;
    else                       rd_prev_q <= rd_now;
  end

  // The access closes in the cycle where the qualification falls.
  assign rd_end = rd_prev_q & ~rd_now;

  function automatic logic rd_rst_active(input logic rn);
    return rn;
  endfunction

endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_end,
  output logic tgl
);

  logic tgl_q;

  // The state advances once per finished access, only while programming runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tgl_q <= 1'b0;
    else if (rd_end && busy) tgl_q <= ~tgl_q;
  end

  assign tgl = tgl_q;

endmodule

// File: rtl/wsr_out_mux.sv
module wsr_out_mux
  import wsr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_now,
  input  logic              busy,
  input  logic              tgl,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);

  localparam logic [DATA_W-1:0] ZERO_W = '0;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] next_w;
  bit_src_e          src;

  // Per-bit status construction; the positions of the two flag bits are parameters.
  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == POLL_BIT) begin : g_poll
      assign status_w[b] = ~last_wr[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_w[b] = tgl;
    end else begin : g_copy
      assign status_w[b] = last_wr[b];
    end
  end

  assign src = pick_src(rd_now, busy);

  always_comb begin
    unique case (src)
      SRC_STATUS: next_w = status_w;
      SRC_ARRAY:  next_w = arr_rdata;
      default:    next_w = ZERO_W;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= ZERO_W;
      rd_oe   <= 1'b0;
    end else begin
      rd_data <= next_w;
      rd_oe   <= rd_now;
    end
  end

endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              oen_n,
  input  logic              wen_n,
  input  logic              prog_busy,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);

  logic rd_now;
  logic rd_end;
  logic tgl_state;

  wsr_access_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .oen_n  (oen_n),
    .wen_n  (wen_n),
    .rd_now (rd_now),
    .rd_end (rd_end)
  );

  wsr_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (prog_busy),
    .rd_end (rd_end),
    .tgl    (tgl_state)
  );

  wsr_out_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_now    (rd_now),
    .busy      (prog_busy),
    .tgl       (tgl_state),
    .last_wr   (last_wr),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe)
  );

endmodule

// File: rtl/wsr_chk.sv
module wsr_chk #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              oen_n,
  input logic              wen_n,
  input logic              prog_busy,
  input logic [DATA_W-1:0] last_wr,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe,
  input logic              tgl_state
);

  logic qual;
  assign qual = ~sel_n & ~oen_n & wen_n;

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> rd_oe); // R1

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (!rd_oe && rd_data == '0)); // R1

  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !prog_busy) |=> rd_data == $past(arr_rdata)); // R2 R8

  AST_POLL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && prog_busy) |=> rd_data[POLL_BIT] == ~$past(last_wr[POLL_BIT])); // R3

  AST_TOGGLE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && prog_busy) |=> rd_data[TOG_BIT] == $past(tgl_state)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_busy |=> $stable(tgl_state)); // R6

  AST_ACCESS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && qual && prog_busy && $past(prog_busy)) |=> $stable(rd_data[TOG_BIT])); // R10

endmodule

bind wr_status_resp wsr_chk #(
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT),
  .TOG_BIT  (TOG_BIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .oen_n     (oen_n),
  .wen_n     (wen_n),
  .prog_busy (prog_busy),
  .last_wr   (last_wr),
  .arr_rdata (arr_rdata),
  .rd_data   (rd_data),
  .rd_oe     (rd_oe),
  .tgl_state (tgl_state)
);

// File: tb/wr_status_resp_tb_top.sv
module wr_status_resp_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       oen_n = 1'b1;
  logic       wen_n = 1'b1;
  logic       prog_busy = 1'b0;
  logic [7:0] last_wr = 8'h00;
  logic [7:0] arr_rdata = 8'h00;
  logic [7:0] rd_data;
  logic       rd_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wr_status_resp dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .oen_n     (oen_n),
    .wen_n     (wen_n),
    .prog_busy (prog_busy),
    .last_wr   (last_wr),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe)
  );

  typedef struct packed {
    logic       s_n;
    logic       o_n;
    logic       w_n;
    logic       bsy;
    logic [7:0] lw;
    logic [7:0] ar;
    logic       x_oe;
    logic [7:0] x_d;
    logic [7:0] req;
  } vec_t;

  // One vector per cycle; the toggle state starts at 0 after reset.
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd1},  // R1 idle bus
    '{1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h3C, 1'b1, 8'h3C, 8'd2},  // R2 true data
    '{1'b0,1'b0,1'b1,1'b0, 8'h00, 8'hA5, 1'b1, 8'hA5, 8'd2},  // R2 true data
    '{1'b1,1'b0,1'b1,1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd1},  // R1 deselected
    '{1'b0,1'b0,1'b1,1'b1, 8'h9A, 8'h11, 1'b1, 8'h1A, 8'd3},  // R3 R5 poll, tgl 0
    '{1'b0,1'b0,1'b1,1'b1, 8'h9A, 8'h22, 1'b1, 8'h1A, 8'd10}, // R10 same access
    '{1'b0,1'b1,1'b1,1'b1, 8'h9A, 8'h00, 1'b0, 8'h00, 8'd7},  // R7 end by oe, flip
    '{1'b0,1'b0,1'b1,1'b1, 8'h9A, 8'h00, 1'b1, 8'h5A, 8'd4},  // R4 tgl 1
    '{1'b1,1'b0,1'b1,1'b1, 8'h9A, 8'h00, 1'b0, 8'h00, 8'd7},  // R7 end by sel, flip
    '{1'b0,1'b0,1'b1,1'b1, 8'h40, 8'h00, 1'b1, 8'h80, 8'd4},  // R4 tgl 0
    '{1'b0,1'b0,1'b0,1'b1, 8'h40, 8'h00, 1'b0, 8'h00, 8'd7},  // R7 end by write strobe
    '{1'b0,1'b0,1'b1,1'b1, 8'h40, 8'h00, 1'b1, 8'hC0, 8'd4},  // R4 tgl 1
    '{1'b0,1'b0,1'b1,1'b0, 8'h40, 8'h77, 1'b1, 8'h77, 8'd8},  // R8 busy drops
    '{1'b1,1'b1,1'b1,1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd6},  // R6 end, no flip
    '{1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 8'd2},  // R2 zero data
    '{1'b1,1'b1,1'b1,1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd6},  // R6 end, no flip
    '{1'b0,1'b0,1'b1,1'b1, 8'h00, 8'hFF, 1'b1, 8'hC0, 8'd6},  // R6 tgl still 1
    '{1'b1,1'b1,1'b1,1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 8'd4},  // R4 end, flip
    '{1'b0,1'b0,1'b1,1'b1, 8'hFF, 8'h00, 1'b1, 8'h3F, 8'd5},  // R5 tgl 0
    '{1'b1,1'b1,1'b1,1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd6}   // R6 end while idle
  };

  task automatic check(input logic x_oe, input logic [7:0] x_d, input int r);
    n_run++;
    if (rd_oe !== x_oe || rd_data !== x_d) begin
      n_fail++;
      $display("FAIL R%0d: oe=%0b data=%02h expected oe=%0b data=%02h",
               r, rd_oe, rd_data, x_oe, x_d);
    end
  endtask

  task automatic drive(input logic s, input logic o, input logic w, input logic b,
                       input logic [7:0] lw, input logic [7:0] ar);
    sel_n = s; oen_n = o; wen_n = w; prog_busy = b; last_wr = lw; arr_rdata = ar;
  endtask

  task automatic step(input logic s, input logic o, input logic w, input logic b,
                      input logic [7:0] lw, input logic [7:0] ar,
                      input logic x_oe, input logic [7:0] x_d, input int r);
    drive(s, o, w, b, lw, ar);
    @(negedge clk);
    check(x_oe, x_d, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 8'h00, 9); // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 8'h00, 9); // R9 idle after release

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].s_n, VECS[i].o_n, VECS[i].w_n, VECS[i].bsy,
           VECS[i].lw, VECS[i].ar, VECS[i].x_oe, VECS[i].x_d, int'(VECS[i].req));
    end

    // R9: reset during an access clears the bus and the toggle state.
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 8'h80, 4); // tgl 0
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 4); // flip to 1
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    #1 rst_n = 1'b0;
    #1 check(1'b0, 8'h00, 9); // R9 async clear
    @(negedge clk);
    check(1'b0, 8'h00, 9);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 8'h80, 9); // R9 tgl back to 0
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 4); // flip to 1

    // R10: a long busy access keeps the status byte constant while array data moves.
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, 8'h2B, 8'(k * 8'h31), 1'b1, 8'hEB, 10);
    end
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1);

    finish_run();
  end

endmodule